// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral for a system bus. A 16-bit down counter decrements on a slow tick. The tick comes from the core clock through two stages: an 8-bit prescaler that divides by (P+1), followed by a power-of-two divider that divides by 16, 32, 64 or 128. When the counter is zero on a tick, the block has expired. It can then emit a one-cycle reset request, set a sticky interrupt flag, or do both. In every case the counter reloads from the reload register and keeps running.

Software reaches four 32-bit registers through a single-cycle strobe interface with a 2-bit word index:

| Index | Register |
|---|---|
| 0 | control |
| 1 | reload |
| 2 | count |
| 3 | interrupt clear |

Software can stop the counter, reprogram it, read the live count, or overwrite the count at any time.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x0000_8039 (prescaler 0x80, divider code 3, counting on, reset request on, interrupt off). The reload and count registers read 0x8000, and both `irq_o` and `rst_req_o` are low.
- R2: Word index 0 is control, 1 is reload, 2 is count and 3 is interrupt clear.
  - The control register holds the reset-request enable in bit 0, the interrupt enable in bit 2, the divider code in bits 4:3, the run bit in bit 5 and the prescaler in bits 15:8. All other bits read as zero.
  - Reload and count hold 16 bits and read zero above bit 15. The clear register reads as zero.
  - Read data appears on `bus_rdata_o` one cycle after the read strobe.
- R3: The tick period is (P+1)·F core cycles, where P is the prescaler field and F is 16, 32, 64 or 128 for divider codes 0, 1, 2 and 3.
- R4: Each tick lowers a nonzero count by one. After the run bit is set, the first decrement lands exactly one full tick period later, because both divider stages start from zero.
- R5: A tick that finds the count at zero loads the count from the reload register, and counting continues.
- R6: On each expiry with bit 0 set, `rst_req_o` is high for exactly one cycle. With bit 0 clear, it stays low.
- R7: On expiry with bit 2 set, `irq_o` goes high and stays high until cleared. With bit 2 clear, it is not set.
- R8: Any write to the clear register, whatever the data, drops `irq_o` in the next cycle.
- R9: A write to the count register loads the new value in the next cycle, whether or not the timer is running. The write takes priority over a tick in the same cycle.
- R10: With the run bit clear, the divider stages are held at zero, no tick occurs and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Single-cycle access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| irq_o | output | 1 | Sticky expiry interrupt flag |

## Verification
A write takes effect at the clock edge that samples it. Read data is due one cycle after the read strobe, so the bench samples it on the following falling edge.

A decrement lands N = (P+1)·F edges after the enabling write, and then every N edges. A trial stops the timer m edges after it was started, so exactly floor(m/N) ticks have occurred. The bench then reads the frozen count at leisure and compares it with a bench model that applies those ticks with wrap to the reload value.

The reset request follows the expiring tick by one register stage. A falling-edge monitor counts those pulses and flags any pulse wider than one cycle. The interrupt flag is sampled after the timer has stopped and after a clear write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int PRE_W     = 8;
    localparam int DIV_SEL_W = 2;

    // Control bit positions; software drivers decode these.
    localparam int BIT_RST_EN = 0;
    localparam int BIT_IRQ_EN = 2;
    localparam int BIT_DIV_LO = 3;
    localparam int BIT_RUN    = 5;
    localparam int BIT_PRE_LO = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0]     presc;
        logic                 run;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 irq_en;
        logic                 rst_en;
    } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int                   CNT_W       = 16,
    parameter logic [PRE_W-1:0]     RST_PRESC   = 8'h80,
    parameter logic [DIV_SEL_W-1:0] RST_DIV     = 2'd3,
    parameter logic                 RST_RUN     = 1'b1,
    parameter logic                 RST_RST_EN  = 1'b1,
    parameter logic                 RST_IRQ_EN  = 1'b0,
    parameter logic [CNT_W-1:0]     RST_RELOAD  = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              cnt_load_o,
    output logic [CNT_W-1:0]  cnt_load_val_o,
    output logic              irq_clr_o,
    output logic [DATA_W-1:0] bus_rdata_o
);

    localparam int PAD_W = DATA_W - CNT_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  reload;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_en, rd_en;
    logic [DATA_W-1:0] rd_val;
    reg_sel_e sel;

    always_comb begin
        sel    = reg_sel_e'(bus_addr_i);
        wr_en  = bus_sel_i && bus_we_i;
        rd_en  = bus_sel_i && !bus_we_i;
        regs_d = regs_q;

        rd_val = '0;
        case (sel)
            REG_CTRL: begin
                rd_val[BIT_RST_EN]               = regs_q.ctrl.rst_en;
                rd_val[BIT_IRQ_EN]               = regs_q.ctrl.irq_en;
                rd_val[BIT_DIV_LO +: DIV_SEL_W]  = regs_q.ctrl.div_sel;
                rd_val[BIT_RUN]                  = regs_q.ctrl.run;
                rd_val[BIT_PRE_LO +: PRE_W]      = regs_q.ctrl.presc;
            end
            REG_RELOAD: rd_val = {{PAD_W{1'b0}}, regs_q.reload};
            REG_COUNT:  rd_val = {{PAD_W{1'b0}}, count_i};
            default:    rd_val = '0;
        endcase

        if (wr_en) begin
            case (sel)
                REG_CTRL: begin
                    regs_d.ctrl.rst_en  = bus_wdata_i[BIT_RST_EN];
                    regs_d.ctrl.irq_en  = bus_wdata_i[BIT_IRQ_EN];
                    regs_d.ctrl.div_sel = bus_wdata_i[BIT_DIV_LO +: DIV_SEL_W];
                    regs_d.ctrl.run     = bus_wdata_i[BIT_RUN];
                    regs_d.ctrl.presc   = bus_wdata_i[BIT_PRE_LO +: PRE_W];
                end
                REG_RELOAD: regs_d.reload = bus_wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end

        if (rd_en) begin
            regs_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl.presc   <= RST_PRESC;
            regs_q.ctrl.run     <= RST_RUN;
            regs_q.ctrl.div_sel <= RST_DIV;
            regs_q.ctrl.irq_en  <= RST_IRQ_EN;
            regs_q.ctrl.rst_en  <= RST_RST_EN;
            regs_q.reload       <= RST_RELOAD;
            regs_q.rdata        <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_o         = regs_q.ctrl;
    assign reload_o       = regs_q.reload;
    assign cnt_load_o     = wr_en && (sel == REG_COUNT);
    assign cnt_load_val_o = bus_wdata_i[CNT_W-1:0];
    assign irq_clr_o      = wr_en && (sel == REG_CLEAR);
    assign bus_rdata_o    = regs_q.rdata;

    // R2: read data changes only in response to a read strobe
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && !bus_we_i) |=> $stable(bus_rdata_o));

    // R2: a read of the clear register returns zero
    a_r2_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_we_i && bus_addr_i == REG_CLEAR) |=> (bus_rdata_o == '0));

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int PRE_W        = 8,
    parameter int DIV_SEL_W    = 2,
    parameter int DIV_BASE_LOG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic [PRE_W-1:0]     presc_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    output logic                 tick_o
);

    localparam int NUM_DIV = 1 << DIV_SEL_W;
    localparam int DIV_W   = DIV_BASE_LOG + NUM_DIV - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } tick_t;

    tick_t tk_d, tk_q;
    logic [DIV_W-1:0] div_last;
    logic pre_end, div_end;

    always_comb begin
        div_last = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (div_sel_i == DIV_SEL_W'(i)) begin
                div_last = DIV_W'((32'd1 << (DIV_BASE_LOG + i)) - 32'd1);
            end
        end

        // >= keeps the stages from running away if software shrinks a field mid-period
        pre_end = (tk_q.pre >= presc_i);
        div_end = (tk_q.div >= div_last);
        tick_o  = run_i && pre_end && div_end;

        tk_d = tk_q;
        if (!run_i) begin
            tk_d.pre = '0;
            tk_d.div = '0;
        end else if (pre_end) begin
            tk_d.pre = '0;
            tk_d.div = div_end ? '0 : tk_q.div + 1'b1;
        end else begin
            tk_d.pre = tk_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_q <= '0;
        end else begin
            tk_q <= tk_d;
        end
    end

    // R3: the smallest period is 16 cycles, so ticks never come back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R10: stopping clears both stages, so no tick can follow a stopped cycle
    a_r10_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !tick_o);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int               CNT_W     = 16,
    parameter logic [CNT_W-1:0] RST_COUNT = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             rst_en_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             rst_req_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst_req;
        logic             irq;
    } cnt_t;

    cnt_t cs_d, cs_q;
    logic expire;

    always_comb begin
        cs_d         = cs_q;
        cs_d.rst_req = 1'b0;
        expire       = 1'b0;

        if (load_i) begin
            cs_d.cnt = load_val_i;
        end else if (tick_i) begin
            if (cs_q.cnt == '0) begin
                expire   = 1'b1;
                cs_d.cnt = reload_i;
            end else begin
                cs_d.cnt = cs_q.cnt - 1'b1;
            end
        end

        cs_d.rst_req = expire && rst_en_i;

        if (irq_clr_i) begin
            cs_d.irq = 1'b0;
        end
        if (expire && irq_en_i) begin
            cs_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.cnt     <= RST_COUNT;
            cs_q.rst_req <= 1'b0;
            cs_q.irq     <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign count_o   = cs_q.cnt;
    assign rst_req_o = cs_q.rst_req;
    assign irq_o     = cs_q.irq;

    // R4: a tick lowers a nonzero count by one
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

    // R5: a tick at zero restores the reload value
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o == '0) |=> (count_o == $past(reload_i)));

    // R6: the reset request lasts exactly one cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R6: the reset request only follows a tick
    a_r6_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(tick_i));

    // R7: the interrupt flag holds until a clear write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);

    // R8: a clear write with no expiry in the same cycle drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !tick_i) |=> !irq_o);

    // R9: a count write wins over everything else
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i)));

    // R10: without a tick or a load the count does not move
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_o));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int                   CNT_W        = 16,
    parameter int                   DIV_BASE_LOG = 4,
    parameter logic [PRE_W-1:0]     RST_PRESC    = 8'h80,
    parameter logic [DIV_SEL_W-1:0] RST_DIV      = 2'd3,
    parameter logic                 RST_RUN      = 1'b1,
    parameter logic                 RST_RST_EN   = 1'b1,
    parameter logic                 RST_IRQ_EN   = 1'b0,
    parameter logic [CNT_W-1:0]     RST_RELOAD   = 16'h8000,
    parameter logic [CNT_W-1:0]     RST_COUNT    = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              rst_req_o,
    output logic              irq_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] load_val;
    logic             load;
    logic             irq_clr;
    logic             tick;

    wdog_regs #(
        .CNT_W      (CNT_W),
        .RST_PRESC  (RST_PRESC),
        .RST_DIV    (RST_DIV),
        .RST_RUN    (RST_RUN),
        .RST_RST_EN (RST_RST_EN),
        .RST_IRQ_EN (RST_IRQ_EN),
        .RST_RELOAD (RST_RELOAD)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_sel_i      (bus_sel_i),
        .bus_we_i       (bus_we_i),
        .bus_addr_i     (bus_addr_i),
        .bus_wdata_i    (bus_wdata_i),
        .count_i        (count),
        .ctrl_o         (ctrl),
        .reload_o       (reload),
        .cnt_load_o     (load),
        .cnt_load_val_o (load_val),
        .irq_clr_o      (irq_clr),
        .bus_rdata_o    (bus_rdata_o)
    );

    wdog_tick #(
        .PRE_W        (PRE_W),
        .DIV_SEL_W    (DIV_SEL_W),
        .DIV_BASE_LOG (DIV_BASE_LOG)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .presc_i   (ctrl.presc),
        .div_sel_i (ctrl.div_sel),
        .tick_o    (tick)
    );

    wdog_count #(
        .CNT_W     (CNT_W),
        .RST_COUNT (RST_COUNT)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (load_val),
        .reload_i   (reload),
        .rst_en_i   (ctrl.rst_en),
        .irq_en_i   (ctrl.irq_en),
        .irq_clr_i  (irq_clr),
        .count_o    (count),
        .rst_req_o  (rst_req_o),
        .irq_o      (irq_o)
    );

endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    int wide     = 0;
    logic prev_req = 1'b0;

    always #5 clk = ~clk;

    wdog_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .rst_req_o   (rst_req),
        .irq_o       (irq)
    );

    // Pulse monitor for R6: counts pulses and flags any that last two samples.
    always @(negedge clk) begin
        if (rst_req) pulses++;
        if (rst_req && prev_req) wide++;
        prev_req = rst_req;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Caller stands at a falling edge; the write lands on the next rising edge.
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(int p, int dv, bit run, bit ie, bit re);
        return (32'(p) << 8) | (32'(run) << 5) | (32'(dv) << 3) | (32'(ie) << 2) | 32'(re);
    endfunction

    function automatic int model_count(int s, int l, int t);
        int c = s;
        for (int i = 0; i < t; i++) c = (c == 0) ? l : c - 1;
        return c;
    endfunction

    function automatic int model_expiries(int s, int l, int t);
        int c = s;
        int e = 0;
        for (int i = 0; i < t; i++) begin
            if (c == 0) begin c = l; e++; end
            else c = c - 1;
        end
        return e;
    endfunction

    // One timed run: start with count s, reload l, stop m = w+1 edges later.
    task automatic run_trial(input string tag, input int p, input int dv, input bit ie,
                             input bit re, input int s, input int l, input int w);
        logic [31:0] d;
        int n, t, e;
        n = (p + 1) * (16 << dv);
        bus_wr(2'd0, mk_ctrl(p, dv, 1'b0, ie, re));
        bus_wr(2'd1, 32'(l));
        bus_wr(2'd2, 32'(s));
        bus_wr(2'd3, 32'hDEAD_BEEF);
        pulses = 0; wide = 0;
        bus_wr(2'd0, mk_ctrl(p, dv, 1'b1, ie, re));
        repeat (w) @(negedge clk);
        bus_wr(2'd0, mk_ctrl(p, dv, 1'b0, ie, re));
        repeat (2) @(negedge clk);
        t = (w + 1) / n;
        e = model_expiries(s, l, t);
        bus_rd(2'd2, d);
        check({tag, " R4/R5 count"}, d, 32'(model_count(s, l, t)));
        check({tag, " R6 pulses"}, 32'(pulses), re ? 32'(e) : 32'd0);
        check({tag, " R6 width"}, 32'(wide), 32'd0);
        check({tag, " R7 irq"}, {31'd0, irq}, {31'd0, ie && (e > 0)});
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rst_req", {31'd0, rst_req}, 32'd0);
        bus_rd(2'd0, d); check("R1 ctrl", d, 32'h0000_8039);
        bus_rd(2'd1, d); check("R1 reload", d, 32'h0000_8000);
        bus_rd(2'd2, d); check("R1 count", d, 32'h0000_8000);

        // R2: field layout, unused bits, clear register reads zero
        bus_wr(2'd0, 32'hFFFF_FFDF);
        bus_rd(2'd0, d); check("R2 ctrl readback", d, 32'h0000_FF1D);
        bus_wr(2'd1, 32'hABCD_1234);
        bus_rd(2'd1, d); check("R2 reload width", d, 32'h0000_1234);
        bus_rd(2'd3, d); check("R2 clear reads zero", d, 32'd0);

        // R9: count write while stopped
        bus_wr(2'd2, 32'hFFFF_5A5A);
        bus_rd(2'd2, d); check("R9 load stopped", d, 32'h0000_5A5A);

        // R3/R4: first decrement exactly one period after start (N = 16)
        run_trial("R3 m=15", 0, 0, 1'b0, 1'b0, 100, 5, 14);
        run_trial("R3 m=16", 0, 0, 1'b0, 1'b0, 100, 5, 15);
        run_trial("R3 p=2 d=1 m=191", 2, 1, 1'b0, 1'b0, 9, 5, 190);
        run_trial("R3 p=2 d=1 m=192", 2, 1, 1'b0, 1'b0, 9, 5, 191);

        // R5/R6/R7: expiry paths
        run_trial("R5 wrap reset only", 0, 0, 1'b0, 1'b1, 1, 3, 16 * 7 - 1);
        run_trial("R7 wrap irq only", 0, 1, 1'b1, 1'b0, 0, 2, 32 * 5 - 1);

        // R8: any write to the clear register drops the flag
        check("R8 irq before clear", {31'd0, irq}, 32'd1);
        bus_wr(2'd3, 32'd0);
        check("R8 irq after clear", {31'd0, irq}, 32'd0);

        // R9: count write while running takes effect right away
        bus_wr(2'd2, 32'd50);
        bus_wr(2'd0, mk_ctrl(0, 0, 1'b1, 1'b0, 1'b0));
        bus_wr(2'd2, 32'd7);
        bus_wr(2'd0, mk_ctrl(0, 0, 1'b0, 1'b0, 1'b0));
        bus_rd(2'd2, d); check("R9 load running", d, 32'd7);

        // R10: stopped timer holds its count
        repeat (300) @(negedge clk);
        bus_rd(2'd2, d2); check("R10 hold", d2, 32'd7);

        // Random trials
        for (int k = 0; k < 24; k++) begin
            int p, dv, s, l, w, n;
            bit ie, re;
            p  = int'($urandom_range(0, 3));
            dv = int'($urandom_range(0, 2));
            s  = int'($urandom_range(0, 5));
            l  = int'($urandom_range(0, 4));
            ie = 1'($urandom_range(0, 1));
            re = 1'($urandom_range(0, 1));
            n  = (p + 1) * (16 << dv);
            w  = int'($urandom_range(0, 6 * n));
            run_trial($sformatf("rand%0d", k), p, dv, ie, re, s, l, w);
            bus_wr(2'd3, 32'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule